// File: doc/BRIEF.md
# Frame CRC Checker with Error Injection

This block checks a serial stream of data frames, one bit per clock. A frame begins with a start pulse that also carries the payload length. The payload bits follow, and then a 16-bit check value that was computed before transmission. While the payload streams in, the block builds a CRC-16. When the last check bit arrives, it forms a syndrome from the computed value and the received value. A non-zero syndrome raises the error flag and pulls an active-low status line low. Checking never stops. The next frame is accepted as soon as the verdict is out, even while earlier error information is being examined or read.

On the first failing frame the block records that frame's index. It then starts a background search that walks the single-bit error patterns of that frame, so that a one-bit fault can be pinned to its payload offset. A serial readout port captures the current syndrome together with the CRC computed for the very first frame after reset, and shifts them out one bit at a time.

For testing, an injector can be armed to corrupt one chosen frame in one of three ways: one flipped bit, two flipped bits at independent offsets, or two flipped bits at neighbouring offsets.

The control state machine has three states. IDLE waits for a frame. PAYLOAD feeds bits into the CRC. CHECK collects the 16 check bits. The transitions are:
- start: IDLE to PAYLOAD, or IDLE straight to CHECK when the length is zero.
- payload_done: PAYLOAD to CHECK, on the last payload bit.
- verdict: CHECK to IDLE, on the 16th check bit.

The search engine has two states, SEARCH_IDLE and SEARCH_RUN. It leaves SEARCH_RUN on a hit, on exhaustion, or on a clear.

Top module: `frame_crc_checker`

## Requirements
- R1: The CRC uses the polynomial 0x1021 with a seed of 0xFFFF and is processed MSB-first, one payload bit per clock with bit_valid high. It restarts at every frame_start, and frame_len is latched at that pulse. A length of zero is legal and yields the CRC 0xFFFF.
- R2: The 16 check bits follow the payload directly, most significant bit first. In the cycle after the clock edge that takes the last check bit, frame_done is high for exactly one cycle. In that same cycle, syndrome holds computed XOR received. The syndrome changes at no other time.
- R3: crc_error is high exactly when the syndrome is non-zero.
- R4: A verdict with a non-zero syndrome drives status_n low. status_n stays low through later clean frames until clear_loc is pulsed.
- R5: After a failing frame, following frames are checked normally, and a clean frame returns the syndrome to zero.
- R6: The first failing frame sets loc_valid and stores its index in loc_frame. Frame indices count from 0 after reset. The record is sticky until clear_loc. When clear_loc and a new failure fall in the same cycle, the clear wins.
- R7: For a failing frame of length L, the search finishes within L+1 cycles. When the syndrome matches a single flipped payload bit, it sets loc_found and reports that bit's 0-based offset on loc_bit. Otherwise loc_found stays low.
- R8: inj_arm latches inj_mode, inj_frame, inj_pos_a and inj_pos_b. The mode codes are 0 none, 1 single (flip at a), 2 double (flip at a and at b) and 3 adjacent (flip at a and a+1). Flips apply only to the payload of the frame whose index equals inj_frame, and the injector disarms when that frame ends. Other frames are not affected.
- R9: rd_load captures {syndrome, CRC of frame 0} as 32 bits. rd_out shows bit 31, and each rd_shift moves the next lower bit onto rd_out.
- R10: After reset, status_n is 1, and crc_error, loc_valid, loc_found, frame_done and syndrome are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Start-of-frame pulse, accepted in IDLE |
| frame_len | input | LEN_W | Payload length in bits, latched at frame_start |
| bit_valid | input | 1 | bit_in carries a payload or check bit |
| bit_in | input | 1 | Serial data |
| clear_loc | input | 1 | Clears the location record and the low status |
| inj_arm | input | 1 | Latches the injector settings |
| inj_mode | input | 2 | 0 none, 1 single, 2 double, 3 adjacent |
| inj_frame | input | IDX_W | Index of the frame to corrupt |
| inj_pos_a | input | LEN_W | First flip offset |
| inj_pos_b | input | LEN_W | Second flip offset (double mode) |
| rd_load | input | 1 | Capture the readout word |
| rd_shift | input | 1 | Advance the readout by one bit |
| rd_out | output | 1 | Serial readout bit |
| frame_done | output | 1 | One-cycle verdict pulse |
| syndrome | output | 16 | Computed XOR received check value |
| crc_error | output | 1 | Syndrome is non-zero |
| status_n | output | 1 | Active-low sticky mismatch status |
| loc_valid | output | 1 | A failing frame has been recorded |
| loc_frame | output | IDX_W | Index of the first failing frame |
| loc_found | output | 1 | Search located a single-bit error |
| loc_bit | output | LEN_W | Payload offset of the located bit |
| search_busy | output | 1 | Location search running |

## Verification
The checker watches the properties that hold on every cycle:
- the syndrome moves only with a verdict pulse;
- the verdict pulse lasts a single cycle;
- a failing verdict pulls status_n low;
- the location record stays put until cleared, and a clear always wins;
- a located bit never appears without a recorded frame.

The CRC values, the syndromes produced by each injection mode, the offset that the search reports, the one-frame reach of the injector and the serial readout order all depend on the data. Only the bench's directed scenarios can show them, by comparing against values the bench computes independently.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;
    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PAYLOAD = 2'd1,
        ST_CHECK   = 2'd2
    } chk_state_t;

    typedef enum logic [1:0] {
        INJ_NONE   = 2'd0,
        INJ_SINGLE = 2'd1,
        INJ_DOUBLE = 2'd2,
        INJ_ADJ    = 2'd3
    } inj_mode_t;

    typedef enum logic {
        SRCH_IDLE = 1'b0,
        SRCH_RUN  = 1'b1
    } srch_state_t;

    // One MSB-first step of the CRC shift register.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/frame_crc_injector.sv
module frame_crc_injector
    import frame_crc_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [1:0]       mode,
    input  logic [IDX_W-1:0] frame_sel,
    input  logic [LEN_W-1:0] pos_a,
    input  logic [LEN_W-1:0] pos_b,
    input  logic [IDX_W-1:0] cur_frame,
    input  logic             in_payload,
    input  logic [LEN_W-1:0] bit_idx,
    input  logic             frame_end,
    output logic             flip
);
    logic             armed;
    inj_mode_t        mode_q;
    logic [IDX_W-1:0] frame_q;
    logic [LEN_W-1:0] a_q, b_q;
    logic             hit_a, hit_b, hit_adj, target;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            mode_q  <= INJ_NONE;
            frame_q <= '0;
            a_q     <= '0;
            b_q     <= '0;
        end else if (arm) begin
            armed   <= (mode != 2'd0);
            mode_q  <= inj_mode_t'(mode);
            frame_q <= frame_sel;
            a_q     <= pos_a;
            b_q     <= pos_b;
        end else if (frame_end && cur_frame == frame_q) begin
            armed   <= 1'b0;
        end
    end

    assign hit_a   = (bit_idx == a_q);
    assign hit_b   = (bit_idx == b_q);
    assign hit_adj = (bit_idx == a_q + LEN_W'(1));
    assign target  = armed && in_payload && (cur_frame == frame_q);

    always_comb begin
        flip = 1'b0;
        unique case (mode_q)
            INJ_NONE:   flip = 1'b0;
            INJ_SINGLE: flip = target && hit_a;
            INJ_DOUBLE: flip = target && (hit_a || hit_b);
            INJ_ADJ:    flip = target && (hit_a || hit_adj);
            default:    flip = 1'b0;
        endcase
    end
endmodule

// File: rtl/frame_crc_search.sv
module frame_crc_search
    import frame_crc_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             start,
    input  logic [CRC_W-1:0] syn_in,
    input  logic [LEN_W-1:0] len_in,
    output logic             busy,
    output logic             found,
    output logic [LEN_W-1:0] bit_pos
);
    // Syndrome of a single flip on the last payload bit, from a zero register.
    localparam logic [CRC_W-1:0] LAST_BIT_PAT = CRC_POLY;

    srch_state_t      st;
    logic [CRC_W-1:0] cand, syn_q;
    logic [LEN_W-1:0] off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= SRCH_IDLE;
            cand    <= '0;
            syn_q   <= '0;
            off     <= '0;
            found   <= 1'b0;
            bit_pos <= '0;
        end else if (clear) begin
            st      <= SRCH_IDLE;
            found   <= 1'b0;
            bit_pos <= '0;
        end else if (start) begin
            st      <= (len_in != '0) ? SRCH_RUN : SRCH_IDLE;
            cand    <= LAST_BIT_PAT;
            syn_q   <= syn_in;
            off     <= len_in - LEN_W'(1);
            found   <= 1'b0;
        end else begin
            unique case (st)
                SRCH_IDLE: ;
                SRCH_RUN: begin
                    if (cand == syn_q) begin
                        found   <= 1'b1;
                        bit_pos <= off;
                        st      <= SRCH_IDLE;
                    end else if (off == '0) begin
                        st      <= SRCH_IDLE;
                    end else begin
                        cand    <= crc_step(cand, 1'b0);
                        off     <= off - LEN_W'(1);
                    end
                end
                default: st <= SRCH_IDLE;
            endcase
        end
    end

    assign busy = (st == SRCH_RUN);
endmodule

// File: rtl/frame_crc_readout.sv
module frame_crc_readout
    import frame_crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [CRC_W-1:0] syn_in,
    input  logic [CRC_W-1:0] first_in,
    output logic             ser_out
);
    logic [2*CRC_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh <= '0;
        else if (load)  sh <= {syn_in, first_in};
        else if (shift) sh <= {sh[2*CRC_W-2:0], 1'b0};
    end

    assign ser_out = sh[2*CRC_W-1];
endmodule

// File: rtl/frame_crc_checker.sv
module frame_crc_checker
    import frame_crc_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             clear_loc,
    input  logic             inj_arm,
    input  logic [1:0]       inj_mode,
    input  logic [IDX_W-1:0] inj_frame,
    input  logic [LEN_W-1:0] inj_pos_a,
    input  logic [LEN_W-1:0] inj_pos_b,
    input  logic             rd_load,
    input  logic             rd_shift,
    output logic             rd_out,
    output logic             frame_done,
    output logic [15:0]      syndrome,
    output logic             crc_error,
    output logic             status_n,
    output logic             loc_valid,
    output logic [IDX_W-1:0] loc_frame,
    output logic             loc_found,
    output logic [LEN_W-1:0] loc_bit,
    output logic             search_busy
);
    localparam logic [LEN_W-1:0] LAST_CHK = LEN_W'(CRC_W - 1);

    chk_state_t       state, nstate;
    logic [CRC_W-1:0] crc_q, rx_q, first_crc, rx_next, syn_next;
    logic [LEN_W-1:0] len_q, bit_cnt;
    logic [IDX_W-1:0] frame_idx;
    logic             first_seen, flip, last_pay, last_check, fail_now, srch_start;

    assign last_pay   = (state == ST_PAYLOAD) && bit_valid && (bit_cnt == len_q - LEN_W'(1));
    assign last_check = (state == ST_CHECK) && bit_valid && (bit_cnt == LAST_CHK);
    assign rx_next    = {rx_q[CRC_W-2:0], bit_in};
    assign syn_next   = crc_q ^ rx_next;
    assign fail_now   = last_check && (syn_next != '0);
    assign srch_start = fail_now && !loc_valid && !clear_loc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Transitions: start, payload_done, verdict
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:    if (frame_start) nstate = (frame_len == '0) ? ST_CHECK : ST_PAYLOAD;
            ST_PAYLOAD: if (last_pay)    nstate = ST_CHECK;
            ST_CHECK:   if (last_check)  nstate = ST_IDLE;
            default:    nstate = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q      <= CRC_SEED;
            rx_q       <= '0;
            len_q      <= '0;
            bit_cnt    <= '0;
            frame_idx  <= '0;
            frame_done <= 1'b0;
            syndrome   <= '0;
            first_crc  <= '0;
            first_seen <= 1'b0;
            status_n   <= 1'b1;
            loc_valid  <= 1'b0;
            loc_frame  <= '0;
        end else begin
            frame_done <= 1'b0;
            unique case (state)
                ST_IDLE: if (frame_start) begin
                    crc_q   <= CRC_SEED;
                    len_q   <= frame_len;
                    bit_cnt <= '0;
                end
                ST_PAYLOAD: if (bit_valid) begin
                    crc_q   <= crc_step(crc_q, bit_in ^ flip);
                    bit_cnt <= last_pay ? '0 : bit_cnt + LEN_W'(1);
                end
                ST_CHECK: if (bit_valid) begin
                    rx_q    <= rx_next;
                    bit_cnt <= bit_cnt + LEN_W'(1);
                    if (last_check) begin
                        frame_done <= 1'b1;
                        syndrome   <= syn_next;
                        frame_idx  <= frame_idx + IDX_W'(1);
                        if (!first_seen) begin
                            first_crc  <= crc_q;
                            first_seen <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase

            if (clear_loc) begin
                status_n  <= 1'b1;
                loc_valid <= 1'b0;
            end else if (fail_now) begin
                status_n <= 1'b0;
                if (!loc_valid) begin
                    loc_valid <= 1'b1;
                    loc_frame <= frame_idx;
                end
            end
        end
    end

    assign crc_error = (syndrome != '0);

    frame_crc_injector #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_inj (
        .clk(clk), .rst_n(rst_n), .arm(inj_arm), .mode(inj_mode),
        .frame_sel(inj_frame), .pos_a(inj_pos_a), .pos_b(inj_pos_b),
        .cur_frame(frame_idx), .in_payload(state == ST_PAYLOAD),
        .bit_idx(bit_cnt), .frame_end(last_check), .flip(flip)
    );

    frame_crc_search #(.LEN_W(LEN_W)) u_srch (
        .clk(clk), .rst_n(rst_n), .clear(clear_loc), .start(srch_start),
        .syn_in(syn_next), .len_in(len_q), .busy(search_busy),
        .found(loc_found), .bit_pos(loc_bit)
    );

    frame_crc_readout u_rd (
        .clk(clk), .rst_n(rst_n), .load(rd_load), .shift(rd_shift),
        .syn_in(syndrome), .first_in(first_crc), .ser_out(rd_out)
    );
endmodule

// File: rtl/frame_crc_checker_sva.sv
module frame_crc_checker_sva #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_loc,
    input logic             frame_done,
    input logic [15:0]      syndrome,
    input logic             status_n,
    input logic             loc_valid,
    input logic [IDX_W-1:0] loc_frame,
    input logic             loc_found
);
    // R2: the syndrome moves only together with a verdict pulse
    a_r2_syndrome_on_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable(syndrome));

    // R2: the verdict pulse lasts one cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R4: a failing verdict drives status low unless a clear just happened
    a_r4_fail_status_low: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && syndrome != 16'h0 && !$past(clear_loc)) |-> !status_n);

    // R6: the location record is sticky until cleared
    a_r6_loc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && !clear_loc) |=> (loc_valid && $stable(loc_frame)));

    // R6: clear wins over a new failure
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear_loc |=> (!loc_valid && status_n));

    // R7: a located bit always belongs to a recorded frame
    a_r7_found_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
        loc_found |-> loc_valid);
endmodule

bind frame_crc_checker frame_crc_checker_sva #(.IDX_W(IDX_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .clear_loc(clear_loc), .frame_done(frame_done),
    .syndrome(syndrome), .status_n(status_n), .loc_valid(loc_valid),
    .loc_frame(loc_frame), .loc_found(loc_found)
);

// File: tb/frame_crc_checker_test.sv
module frame_crc_checker_test;
    localparam int LEN_W = 12;
    localparam int IDX_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic [LEN_W-1:0] frame_len = '0;
    logic             bit_valid = 1'b0;
    logic             bit_in = 1'b0;
    logic             clear_loc = 1'b0;
    logic             inj_arm = 1'b0;
    logic [1:0]       inj_mode = 2'd0;
    logic [IDX_W-1:0] inj_frame = '0;
    logic [LEN_W-1:0] inj_pos_a = '0;
    logic [LEN_W-1:0] inj_pos_b = '0;
    logic             rd_load = 1'b0;
    logic             rd_shift = 1'b0;
    logic             rd_out, frame_done, crc_error, status_n;
    logic             loc_valid, loc_found, search_busy;
    logic [15:0]      syndrome;
    logic [IDX_W-1:0] loc_frame;
    logic [LEN_W-1:0] loc_bit;

    int checks = 0;
    int failures = 0;
    logic [15:0] frame0_crc;

    always #10 clk = ~clk;

    frame_crc_checker #(.LEN_W(LEN_W), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_len(frame_len),
        .bit_valid(bit_valid), .bit_in(bit_in), .clear_loc(clear_loc),
        .inj_arm(inj_arm), .inj_mode(inj_mode), .inj_frame(inj_frame),
        .inj_pos_a(inj_pos_a), .inj_pos_b(inj_pos_b), .rd_load(rd_load),
        .rd_shift(rd_shift), .rd_out(rd_out), .frame_done(frame_done),
        .syndrome(syndrome), .crc_error(crc_error), .status_n(status_n),
        .loc_valid(loc_valid), .loc_frame(loc_frame), .loc_found(loc_found),
        .loc_bit(loc_bit), .search_busy(search_busy)
    );

    function automatic logic [15:0] ref_crc(input int len, input logic [63:0] p);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            logic fb = c[15] ^ p[i];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
        end
        return c;
    endfunction

    // Syndrome left by one flipped payload bit at offset pos (linearity of the CRC)
    function automatic logic [15:0] err_pat(input int len, input int pos);
        logic [15:0] c = 16'h0;
        for (int i = pos; i < len; i++) begin
            logic fb = c[15] ^ (i == pos);
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
        end
        return c;
    endfunction

    function automatic int find_pos(input int len, input logic [15:0] s);
        for (int i = len - 1; i >= 0; i--)
            if (err_pat(len, i) == s) return i;
        return -1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input int len, input logic [63:0] p, input logic [15:0] chk);
        @(negedge clk);
        frame_start = 1'b1;
        frame_len   = LEN_W'(len);
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            bit_valid = 1'b1;
            bit_in    = p[i];
            @(negedge clk);
        end
        for (int j = 15; j >= 0; j--) begin
            bit_valid = 1'b1;
            bit_in    = chk[j];
            @(negedge clk);
        end
        bit_valid = 1'b0;
    endtask

    task automatic pulse_clear();
        clear_loc = 1'b1;
        @(negedge clk);
        clear_loc = 1'b0;
    endtask

    task automatic arm(input logic [1:0] m, input int fr, input int a, input int b);
        @(negedge clk);
        inj_arm   = 1'b1;
        inj_mode  = m;
        inj_frame = IDX_W'(fr);
        inj_pos_a = LEN_W'(a);
        inj_pos_b = LEN_W'(b);
        @(negedge clk);
        inj_arm   = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 status_n", 32'(status_n), 32'd1);
        check("R10 crc_error", 32'(crc_error), 32'd0);
        check("R10 loc_valid", 32'(loc_valid), 32'd0);
        check("R10 loc_found", 32'(loc_found), 32'd0);
        check("R10 frame_done", 32'(frame_done), 32'd0);
        check("R10 syndrome", 32'(syndrome), 32'd0);
    endtask

    task automatic t_clean_first();
        logic [63:0] p = 64'h0000_00A5_3C96_E10F;
        frame0_crc = ref_crc(24, p);
        send_frame(24, p, frame0_crc);
        check("R2 frame_done", 32'(frame_done), 32'd1);
        check("R1 R2 clean syndrome", 32'(syndrome), 32'd0);
        check("R3 clean crc_error", 32'(crc_error), 32'd0);
        @(negedge clk);
        check("R2 done one cycle", 32'(frame_done), 32'd0);
    endtask

    task automatic t_bad_check();
        logic [63:0] p = 64'h0000_1234_5678_9ABC;
        int exp_pos = find_pos(40, 16'h0100);
        send_frame(40, p, ref_crc(40, p) ^ 16'h0100);
        check("R2 bad syndrome", 32'(syndrome), 32'h0100);
        check("R3 crc_error set", 32'(crc_error), 32'd1);
        check("R4 status low", 32'(status_n), 32'd0);
        check("R6 loc_valid", 32'(loc_valid), 32'd1);
        check("R6 loc_frame", 32'(loc_frame), 32'd1);
        repeat (45) @(negedge clk);
        check("R7 search idle", 32'(search_busy), 32'd0);
        check("R7 found matches", 32'(loc_found), 32'(exp_pos >= 0));
    endtask

    task automatic t_continue();
        logic [63:0] p = 64'h0000_0000_0000_F00D;
        send_frame(16, p, ref_crc(16, p));
        check("R5 clean after fail", 32'(syndrome), 32'd0);
        check("R3 error cleared", 32'(crc_error), 32'd0);
        check("R4 status sticky", 32'(status_n), 32'd0);
        check("R6 loc_frame kept", 32'(loc_frame), 32'd1);
        pulse_clear();
        check("R6 clear loc", 32'(loc_valid), 32'd0);
        check("R4 clear status", 32'(status_n), 32'd1);
    endtask

    task automatic t_single();
        logic [63:0] p = 64'h0000_0000_DEAD_BEEF;
        arm(2'd1, 4, 5, 0);
        send_frame(32, p, ref_crc(32, p));
        check("R8 non-target frame untouched", 32'(syndrome), 32'd0);
        send_frame(32, p, ref_crc(32, p));
        check("R8 single syndrome", 32'(syndrome), 32'(err_pat(32, 5)));
        check("R6 loc_frame single", 32'(loc_frame), 32'd4);
        repeat (36) @(negedge clk);
        check("R7 single found", 32'(loc_found), 32'd1);
        check("R7 single offset", 32'(loc_bit), 32'd5);
        send_frame(32, p, ref_crc(32, p));
        check("R8 one-shot disarm", 32'(syndrome), 32'd0);
        pulse_clear();
    endtask

    task automatic t_adjacent();
        logic [63:0] p = 64'h0000_0000_0F0F_3355;
        logic [15:0] e = err_pat(28, 10) ^ err_pat(28, 11);
        arm(2'd3, 6, 10, 0);
        send_frame(28, p, ref_crc(28, p));
        check("R8 adjacent syndrome", 32'(syndrome), 32'(e));
        repeat (32) @(negedge clk);
        check("R7 adjacent search", 32'(loc_found), 32'(find_pos(28, e) >= 0));
        pulse_clear();
    endtask

    task automatic t_double_and_read();
        logic [63:0] p = 64'h0000_ABCD_EF01_2345;
        logic [15:0] e = err_pat(48, 2) ^ err_pat(48, 20);
        logic [31:0] got;
        arm(2'd2, 7, 2, 20);
        send_frame(48, p, ref_crc(48, p));
        check("R8 double syndrome", 32'(syndrome), 32'(e));
        check("R6 loc_frame double", 32'(loc_frame), 32'd7);
        @(negedge clk);
        rd_load = 1'b1;
        @(negedge clk);
        rd_load = 1'b0;
        for (int k = 31; k >= 0; k--) begin
            got[k]   = rd_out;
            rd_shift = 1'b1;
            @(negedge clk);
        end
        rd_shift = 1'b0;
        check("R9 readout word", got, {e, frame0_crc});
        pulse_clear();
    endtask

    task automatic t_zero_and_none();
        arm(2'd0, 9, 0, 0);
        send_frame(0, 64'h0, 16'hFFFF);
        check("R1 zero length", 32'(syndrome), 32'd0);
        send_frame(20, 64'h0000_0000_000F_FFFF, ref_crc(20, 64'h0000_0000_000F_FFFF));
        check("R8 mode none", 32'(syndrome), 32'd0);
        check("R4 no fail status", 32'(status_n), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean_first();      // frame 0
        t_bad_check();        // frame 1
        t_continue();         // frame 2
        t_single();           // frames 3, 4, 5
        t_adjacent();         // frame 6
        t_double_and_read();  // frame 7
        t_zero_and_none();    // frames 8, 9
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule